// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Controller

This block keeps the control state of a routing matrix with eight sources and four sinks. Each sink has a route entry in two banks. A controller first fills a staging bank one entry at a time over a shared address bus. A single global transfer strobe then copies the whole staging bank into the active bank, so every sink changes route in the same clock cycle. Several controllers can be staged one after another and then switched together by one shared transfer strobe.

The active bank drives a one-hot switch-enable vector, with one 8-bit group per sink, and one active-low disable flag per sink. The flag can power down a buffer that follows an unused sink. A separate active-low clear input opens every crosspoint and leaves the staging bank as it was, so the next transfer brings the earlier routing back. When the direction input selects read, the same address bus reports the active entry of the selected sink.

Every control input comes from an asynchronous controller and passes through a two-flop synchroniser. An input change therefore takes effect on the third rising clock edge after it occurs. Strobe transparency is modelled by sampling the strobe level on every clock.

Top module: `xpt_route_ctrl`

## Requirements
- R1: While `rst_n` is low, both banks initialise to the off code 4'b1000. After reset, `sw_en` is all zero, `dis_n` is all zero, every readback returns 4'b1000, and a transfer with no prior writes leaves every sink off.
- R2: While `cs_n`=0, `dir_rd`=0, `clr_n`=1 and `wr_n`=0, the staging entry selected by `b_sel` follows `a_bus`. Value 0 to 3 selects sink 0 to 3. The entry keeps the value that was present when `wr_n` rose, and later changes on `a_bus` have no effect on it.
- R3: Writing staging entries while `salvo_n` is high leaves `sw_en` and `dis_n` unchanged.
- R4: While `salvo_n` is low and `clr_n` is high, all four staging entries are copied into the active bank in the same cycle. After `salvo_n` rises, the active bank holds its value.
- R5: An active code with bit 3 = 0 connects source `code[2:0]` to sink o and sets only `sw_en[o*8 + code[2:0]]` in group o. Bit 3 = 1 makes group o all zero, whatever the lower bits are. One source may feed several sinks. No group ever has more than one bit set.
- R6: `dis_n[o]` is 1 exactly when sink o has an active route with bit 3 = 0.
- R7: While `clr_n` is low, every active entry is cleared to off, so `sw_en` and `dis_n` are all zero and readback returns 4'b1000. The staging bank keeps its contents, and a transfer after `clr_n` rises restores the staged routing.
- R8: A write strobe has no effect on the staging bank while `cs_n` is high or `clr_n` is low.
- R9: With `wr_n` and `salvo_n` both low, a value on `a_bus` flows through the staging entry into the active bank. It reaches `sw_en` within three clock edges.
- R10: While `cs_n`=0 and `dir_rd`=1, the block drives `a_bus` with the active entry selected by `b_sel`. Otherwise `a_bus` is released to high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| cs_n | input | 1 | Active-low chip select |
| dir_rd | input | 1 | Direction: 0 writes staging, 1 reads active bank |
| wr_n | input | 1 | Active-low staging write strobe |
| salvo_n | input | 1 | Active-low global transfer strobe |
| clr_n | input | 1 | Active-low clear of the active bank |
| a_bus | inout | 4 | Route code in, active entry out during readback |
| b_sel | input | 2 | Sink select |
| sw_en | output | 32 | One-hot switch enables, 8 bits per sink |
| dis_n | output | 4 | Active-low per-sink disable flags |

## Verification
The bench builds the block with its default eight sources and four sinks. At that size every one of the nine meaningful route codes per sink can be reached, including off codes whose lower bits are nonzero. Table-driven routings cover distinct sources per sink, one source fanned out to every sink, and mixed off entries. Directed cases cover clear-and-restore, writes blocked by chip select or by clear, and flow-through when both strobes are held low.

// File: rtl/xpt_pkg.sv
// Shared defaults and encodings for the crosspoint route controller.
package xpt_pkg;
    localparam int DEF_INPUTS  = 8;
    localparam int DEF_OUTPUTS = 4;

    // Level of the direction input
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;
endpackage

// File: rtl/xpt_sync.sv
// Two-flop synchroniser for a group of asynchronous control inputs.
// Assumes the bits of the group are quasi-static around their strobes.
module xpt_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/xpt_route_bank.sv
// Staging and active route registers, one entry per sink.
// Staging follows the write data while wr_en is set. The active bank copies
// the next staging value while load is set, so load together with wr_en
// gives flow-through. clear has priority over load and leaves staging alone.
module xpt_route_bank #(
    parameter int NUM_OUT = 4,
    parameter int CW      = 4,
    parameter int SW      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SW-1:0]         sel,
    input  logic [CW-1:0]         din,
    input  logic                  load,
    input  logic                  clear,
    output logic [NUM_OUT*CW-1:0] act_flat
);
    localparam logic [CW-1:0] OFF_CODE = {1'b1, {(CW-1){1'b0}}};

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_entry
            logic [CW-1:0] stg_q;
            logic [CW-1:0] stg_nxt;
            logic [CW-1:0] act_q;

            // Next staging value for this entry
            always_comb begin
                stg_nxt = stg_q;
                if (wr_en && (sel == SW'(o)))
                    stg_nxt = din;
            end

            // Staging register
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= OFF_CODE;
                else        stg_q <= stg_nxt;
            end

            // Active register: clear first, then transfer
            always_ff @(posedge clk) begin
                if (!rst_n)     act_q <= OFF_CODE;
                else if (clear) act_q <= OFF_CODE;
                else if (load)  act_q <= stg_nxt;
            end

            assign act_flat[o*CW +: CW] = act_q;
        end
    endgenerate
endmodule

// File: rtl/xpt_route_decode.sv
// Turns the active route codes into per-sink one-hot switch enables and
// active-low disable flags. The top bit of a code marks the sink as off.
module xpt_route_decode #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 4,
    parameter int CW      = 4
) (
    input  logic [NUM_OUT*CW-1:0]     act_flat,
    output logic [NUM_IN*NUM_OUT-1:0] sw_en,
    output logic [NUM_OUT-1:0]        dis_n
);
    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_sink
            logic [CW-1:0] code;
            assign code = act_flat[o*CW +: CW];

            // One-hot source group for this sink
            always_comb begin
                sw_en[o*NUM_IN +: NUM_IN] = '0;
                for (int i = 0; i < NUM_IN; i++) begin
                    if (!code[CW-1] && (code[CW-2:0] == (CW-1)'(i)))
                        sw_en[o*NUM_IN + i] = 1'b1;
                end
            end

            // Disable flag is high only for a routed sink
            assign dis_n[o] = ~code[CW-1];
        end
    endgenerate
endmodule

// File: rtl/xpt_route_ctrl.sv
// Top of the double-buffered crosspoint route controller.
// All control inputs are asynchronous and pass through two-flop synchronisers.
// Address data is synchronised alongside the strobes. The address bus is
// driven only during readback and assumes the controller has released it then.
module xpt_route_ctrl #(
    parameter int NUM_IN  = xpt_pkg::DEF_INPUTS,
    parameter int NUM_OUT = xpt_pkg::DEF_OUTPUTS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          dir_rd,
    input  logic                          wr_n,
    input  logic                          salvo_n,
    input  logic                          clr_n,
    inout  wire  [$clog2(NUM_IN):0]       a_bus,
    input  logic [$clog2(NUM_OUT)-1:0]    b_sel,
    output logic [NUM_IN*NUM_OUT-1:0]     sw_en,
    output logic [NUM_OUT-1:0]            dis_n
);
    import xpt_pkg::*;

    localparam int CW = $clog2(NUM_IN) + 1;
    localparam int SW = $clog2(NUM_OUT);

    logic          cs_s, wr_s, salvo_s, clr_s;
    logic          dir_bit;
    dir_e          dir_s;
    logic [CW-1:0] a_s;
    logic [SW-1:0] b_s;
    logic          wr_en, load, clear, rd_oe;
    logic [CW-1:0] rd_word;
    logic [NUM_OUT*CW-1:0] act_flat;

    // Control strobes synchronised, idle high (direction idle write)
    xpt_sync #(.WIDTH(5), .RST_VAL(5'b11110)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, wr_n, salvo_n, clr_n, dir_rd}),
        .q     ({cs_s, wr_s, salvo_s, clr_s, dir_bit})
    );

    // Address data synchronised with the same latency as the strobes
    xpt_sync #(.WIDTH(CW + SW), .RST_VAL('0)) u_adr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({a_bus, b_sel}),
        .q     ({a_s, b_s})
    );

    assign dir_s = dir_e'(dir_bit);

    // Command decode from synchronised levels
    always_comb begin
        wr_en = !cs_s && (dir_s == DIR_WRITE) && clr_s && !wr_s;
        load  = !salvo_s && clr_s;
        clear = !clr_s;
        rd_oe = !cs_s && (dir_s == DIR_READ);
    end

    xpt_route_bank #(.NUM_OUT(NUM_OUT), .CW(CW), .SW(SW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (b_s),
        .din      (a_s),
        .load     (load),
        .clear    (clear),
        .act_flat (act_flat)
    );

    xpt_route_decode #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CW(CW)) u_dec (
        .act_flat (act_flat),
        .sw_en    (sw_en),
        .dis_n    (dis_n)
    );

    // Readback mux over the active entries
    always_comb begin
        rd_word = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (b_s == SW'(o))
                rd_word = act_flat[o*CW +: CW];
        end
    end

    assign a_bus = rd_oe ? rd_word : {CW{1'bz}};
endmodule

// File: rtl/xpt_route_chk.sv
// Assertion checker for the crosspoint route controller, bound to the top.
module xpt_route_chk #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      salvo_s,
    input logic                      clr_s,
    input logic [NUM_IN*NUM_OUT-1:0] sw_en,
    input logic [NUM_OUT-1:0]        dis_n
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sw_en == '0));

    // R7
    clr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> ((sw_en == '0) && (dis_n == '0)));

    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (salvo_s && clr_s) |=> $stable(sw_en));

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_grp
            // R5
            one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(sw_en[o*NUM_IN +: NUM_IN]));

            // R6
            dis_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dis_n[o] == (|sw_en[o*NUM_IN +: NUM_IN]));
        end
    endgenerate
endmodule

bind xpt_route_ctrl xpt_route_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .salvo_s (salvo_s),
    .clr_s   (clr_s),
    .sw_en   (sw_en),
    .dis_n   (dis_n)
);

// File: tb/xpt_route_ctrl_bench.sv
// Self-checking bench: table of routings, then directed clear and edge cases.
module xpt_route_ctrl_bench;
    localparam int NI = 8;
    localparam int NO = 4;
    localparam int WAITN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, dir_rd = 1'b0, wr_n = 1'b1, salvo_n = 1'b1, clr_n = 1'b1;
    logic [1:0]  b_sel = '0;
    logic [3:0]  tb_a = '0;
    logic        tb_drive = 1'b1;
    wire  [3:0]  a_bus;
    logic [31:0] sw_en;
    logic [3:0]  dis_n;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign a_bus = tb_drive ? tb_a : 4'bz;

    always #10 clk = ~clk;

    xpt_route_ctrl u_xpt_route_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir_rd(dir_rd), .wr_n(wr_n),
        .salvo_n(salvo_n), .clr_n(clr_n), .a_bus(a_bus), .b_sel(b_sel),
        .sw_en(sw_en), .dis_n(dis_n)
    );

    localparam logic [15:0] ROUTE_TAB [5] = '{
        16'h3210, 16'h2222, 16'h5487, 16'h0868, 16'hF9A8
    };

    function automatic logic [31:0] exp_sw(input logic [15:0] m);
        logic [31:0] r;
        r = '0;
        for (int o = 0; o < NO; o++)
            if (!m[o*4+3]) r[o*NI + int'(m[o*4 +: 3])] = 1'b1;
        return r;
    endfunction

    function automatic logic [3:0] exp_dis(input logic [15:0] m);
        logic [3:0] r;
        for (int o = 0; o < NO; o++) r[o] = !m[o*4+3];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (WAITN) @(negedge clk);
    endtask

    task automatic write_entry(input logic [1:0] sel, input logic [3:0] code);
        b_sel = sel; tb_a = code; cs_n = 1'b0; dir_rd = 1'b0;
        wr_n = 1'b0; settle();
        wr_n = 1'b1; settle();
        tb_a = ~code; settle();
        cs_n = 1'b1;
    endtask

    task automatic salvo();
        salvo_n = 1'b0; settle();
        salvo_n = 1'b1; settle();
    endtask

    task automatic apply(input logic [15:0] m);
        for (int o = 0; o < NO; o++) write_entry(2'(o), m[o*4 +: 4]);
    endtask

    task automatic readback(input logic [1:0] sel, output logic [3:0] val);
        tb_drive = 1'b0; b_sel = sel; dir_rd = 1'b1; cs_n = 1'b0; settle();
        val = a_bus;
        cs_n = 1'b1; dir_rd = 1'b0; settle();
        tb_drive = 1'b1;
    endtask

    task automatic check_routes(input string tag, input logic [15:0] m);
        logic [3:0] rb;
        chk({tag, " sw_en"}, sw_en, exp_sw(m));
        chk({tag, " dis_n"}, {28'd0, dis_n}, {28'd0, exp_dis(m)});
        for (int o = 0; o < NO; o++) begin
            readback(2'(o), rb);
            chk({tag, " R10 readback"}, {28'd0, rb}, {28'd0, m[o*4 +: 4]});
        end
    endtask

    initial begin
        logic [15:0] prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check_routes("R1 reset", 16'h8888);
        salvo();
        chk("R1 salvo after reset", sw_en, 32'd0);

        prev = 16'h8888;
        for (int v = 0; v < 5; v++) begin
            apply(ROUTE_TAB[v]);
            // R3 staging alone leaves outputs alone
            chk("R3 before salvo", sw_en, exp_sw(prev));
            salvo();
            // R2 R4 R5 R6 transfer of the staged table entry
            check_routes("R4 R5 R6 table", ROUTE_TAB[v]);
            prev = ROUTE_TAB[v];
        end

        apply(16'h3210);
        salvo();
        chk("R2 reapply", sw_en, exp_sw(16'h3210));
        // R7 clear opens all crosspoints
        clr_n = 1'b0; settle();
        chk("R7 clear sw_en", sw_en, 32'd0);
        chk("R7 clear dis_n", {28'd0, dis_n}, 32'd0);
        begin
            logic [3:0] rb;
            readback(2'd0, rb);
            chk("R7 clear readback", {28'd0, rb}, 32'h8);
        end
        // R8 write blocked while clear is low
        write_entry(2'd0, 4'd5);
        clr_n = 1'b1; settle();
        chk("R7 active stays open", sw_en, 32'd0);
        salvo();
        check_routes("R7 R8 restore", 16'h3210);

        // R8 write blocked by chip select high
        b_sel = 2'd1; tb_a = 4'd7; dir_rd = 1'b0; cs_n = 1'b1;
        wr_n = 1'b0; settle(); wr_n = 1'b1; settle();
        salvo();
        chk("R8 cs high", sw_en, exp_sw(16'h3210));

        // R9 flow-through with both strobes low
        salvo_n = 1'b0; settle();
        b_sel = 2'd2; tb_a = 4'd6; cs_n = 1'b0; dir_rd = 1'b0;
        wr_n = 1'b0; settle();
        chk("R9 flow through", sw_en, exp_sw(16'h3610));
        wr_n = 1'b1; settle();
        salvo_n = 1'b1; cs_n = 1'b1; settle();
        tb_a = 4'd1; settle();
        chk("R9 hold after rise", sw_en, exp_sw(16'h3610));
        chk("R9 dis_n", {28'd0, dis_n}, {28'd0, exp_dis(16'h3610)});

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule